// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic unit of an 8-bit single-accumulator datapath. Each cycle it takes the working register value W, a register-file operand F, an 8-bit literal K, the current carry flag and a decoded operation code. One clock later it presents the result and the destination the result must go to: the working register or the file register. It also presents next values for the carry (C), digit carry (DC) and zero (Z) flags, each with its own write enable.

The surrounding core owns instruction fetch, the opcode bit-field decode and the register file. It applies the write enables to its status register and routes the result by the destination bit. Each operation writes only its own subset of flags. Both subtraction forms compute "operand minus W". The rotates pass data through the carry. The increment and decrement skip variants raise a skip indication when their result is zero, and they leave every flag alone.

Top module: `acc_alu`

## Requirements
- R1: ADD_F (0x00, F+W) and ADD_L (0x01, K+W) give the 8-bit sum. They write C as the carry out of bit 7, DC as the carry out of bit 3, and Z; all three write enables are high.
- R2: SUB_F (0x02, F−W) and SUB_L (0x03, K−W) give the two's-complement difference. C=1 means no borrow, DC=1 means no borrow out of bit 3, and C, DC and Z are all written.
- R3: AND_F/AND_L (0x04/0x05), IOR_F/IOR_L (0x06/0x07), XOR_F/XOR_L (0x08/0x09), MOV_F (0x0A, result F), INC_F (0x0F), DEC_F (0x10) and COM_F (0x13, bitwise inverse of F) write only Z.
- R4: CLR_F (0x0D) and CLR_W (0x0E) give result 0x00 with Z=1, and only Z is written.
- R5: MOV_WF (0x0B, result W), MOV_L (0x0C, result K), INCSK_F (0x11), DECSK_F (0x12) and SWAP_F (0x16) write no flag.
- R6: RRC_F (0x14) gives {C_in, F[7:1]} with C=F[0]. RLC_F (0x15) gives {F[6:0], C_in} with C=F[7]. Only C is written.
- R7: SWAP_F gives {F[3:0], F[7:4]}.
- R8: dest_f_o follows d_i for every F-operand operation. It is 0 for every literal operation and for CLR_W, and 1 for MOV_WF and CLR_F.
- R9: skip_o is 1 exactly when INCSK_F (F+1) or DECSK_F (F−1) gives a zero result.
- R10: Whenever z_we_o is high, z_o is 1 exactly when result_o is 0x00.
- R11: All outputs are registered: they reflect the inputs of the previous rising edge, and they are all zero while rst_ni is low.
- R12: Opcodes 0x17 to 0x1F behave as no-ops: result 0x00, no flag written, dest_f_o=0, skip_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 5 | Decoded operation code |
| w_i | input | 8 | Working register value |
| f_i | input | 8 | File register operand |
| k_i | input | 8 | Literal operand |
| d_i | input | 1 | Destination bit: 0 = W, 1 = F |
| c_i | input | 1 | Current carry flag |
| result_o | output | 8 | Result |
| dest_f_o | output | 1 | 1 = write result to F, 0 = to W |
| c_o | output | 1 | Next carry |
| dc_o | output | 1 | Next digit carry |
| z_o | output | 1 | Next zero flag |
| c_we_o | output | 1 | Carry write enable |
| dc_we_o | output | 1 | Digit carry write enable |
| z_we_o | output | 1 | Zero write enable |
| skip_o | output | 1 | Skip next instruction |

## Verification
The block holds no state beyond its output register. A wrong operand select, nibble carry or enable decode therefore shows at the ports on the very next cycle, as a bad result or a flag enable raised for the wrong operation. Corner operands are chosen so that each carry chain boundary is crossed: nibble carry without byte carry, exact zero results, and equal subtraction operands. A flag enable that leaks onto a no-flag operation would corrupt status in the core one cycle later, so every case checks all three enables, not only the result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    ADD_F   = 5'h00, ADD_L   = 5'h01,
    SUB_F   = 5'h02, SUB_L   = 5'h03,
    AND_F   = 5'h04, AND_L   = 5'h05,
    IOR_F   = 5'h06, IOR_L   = 5'h07,
    XOR_F   = 5'h08, XOR_L   = 5'h09,
    MOV_F   = 5'h0A, MOV_WF  = 5'h0B,
    MOV_L   = 5'h0C, CLR_F   = 5'h0D,
    CLR_W   = 5'h0E, INC_F   = 5'h0F,
    DEC_F   = 5'h10, INCSK_F = 5'h11,
    DECSK_F = 5'h12, COM_F   = 5'h13,
    RRC_F   = 5'h14, RLC_F   = 5'h15,
    SWAP_F  = 5'h16
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flag_t;
endpackage

// File: rtl/alu_addsub.sv
// a + b, or a - b as a + ~b + 1; carry outs at the half and full width.
module alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_o,
  output logic              dc_o
);
  localparam int HALF = DATA_W / 2;
  localparam int HI_W = DATA_W - HALF;

  logic [DATA_W-1:0] b_eff;
  logic [HALF:0]     lo;
  logic [HI_W:0]     hi;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    lo = {1'b0, a_i[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, sub_i};
    hi = {1'b0, a_i[DATA_W-1:HALF]} + {1'b0, b_eff[DATA_W-1:HALF]}
       + {{HI_W{1'b0}}, lo[HALF]};
    sum_o = {hi[HI_W-1:0], lo[HALF-1:0]};
    c_o   = hi[HI_W];
    dc_o  = lo[HALF];
  end
endmodule

// File: rtl/alu_unary.sv
// Single-operand transforms of the file operand.
module alu_unary #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] f_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] inc_o,
  output logic [DATA_W-1:0] dec_o,
  output logic [DATA_W-1:0] com_o,
  output logic [DATA_W-1:0] rr_o,
  output logic [DATA_W-1:0] rl_o,
  output logic [DATA_W-1:0] swap_o
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    inc_o  = f_i + DATA_W'(1);
    dec_o  = f_i - DATA_W'(1);
    com_o  = ~f_i;
    rr_o   = {c_i, f_i[DATA_W-1:1]};
    rl_o   = {f_i[DATA_W-2:0], c_i};
    swap_o = {f_i[HALF-1:0], f_i[DATA_W-1:HALF]};
  end
endmodule

// File: rtl/alu_ctl.sv
// Per-operation flag enables and destination decode.
module alu_ctl
  import acc_alu_pkg::*;
(
  input  alu_op_e op_i,
  input  logic    d_i,
  output flag_t   we_o,
  output logic    dest_f_o,
  output logic    lit_o,
  output logic    sub_o
);
  always_comb begin
    we_o     = '0;
    dest_f_o = 1'b0;
    lit_o    = 1'b0;
    sub_o    = 1'b0;
    unique case (op_i)
      ADD_F, SUB_F: begin
        we_o = '{c: 1'b1, dc: 1'b1, z: 1'b1};
        dest_f_o = d_i;
        sub_o = (op_i == SUB_F);
      end
      ADD_L, SUB_L: begin
        we_o = '{c: 1'b1, dc: 1'b1, z: 1'b1};
        lit_o = 1'b1;
        sub_o = (op_i == SUB_L);
      end
      AND_F, IOR_F, XOR_F, MOV_F, INC_F, DEC_F, COM_F: begin
        we_o.z = 1'b1;
        dest_f_o = d_i;
      end
      AND_L, IOR_L, XOR_L: begin
        we_o.z = 1'b1;
        lit_o = 1'b1;
      end
      MOV_L:  lit_o = 1'b1;
      MOV_WF: dest_f_o = 1'b1;
      CLR_F: begin
        we_o.z = 1'b1;
        dest_f_o = 1'b1;
      end
      CLR_W:  we_o.z = 1'b1;
      INCSK_F, DECSK_F, SWAP_F: dest_f_o = d_i;
      RRC_F, RLC_F: begin
        we_o.c = 1'b1;
        dest_f_o = d_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] f_i,
  input  logic [DATA_W-1:0] k_i,
  input  logic              d_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] result_o,
  output logic              dest_f_o,
  output logic              c_o,
  output logic              dc_o,
  output logic              z_o,
  output logic              c_we_o,
  output logic              dc_we_o,
  output logic              z_we_o,
  output logic              skip_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  flag_t             we, fl;
  logic              dest_f, lit, sub, skip;
  logic [DATA_W-1:0] opnd, res;
  logic [DATA_W-1:0] as_sum, inc_v, dec_v, com_v, rr_v, rl_v, swap_v;
  logic              as_c, as_dc;

  alu_ctl u_ctl (
    .op_i     (op),
    .d_i      (d_i),
    .we_o     (we),
    .dest_f_o (dest_f),
    .lit_o    (lit),
    .sub_o    (sub)
  );

  assign opnd = lit ? k_i : f_i;

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i   (opnd),
    .b_i   (w_i),
    .sub_i (sub),
    .sum_o (as_sum),
    .c_o   (as_c),
    .dc_o  (as_dc)
  );

  alu_unary #(.DATA_W(DATA_W)) u_unary (
    .f_i    (f_i),
    .c_i    (c_i),
    .inc_o  (inc_v),
    .dec_o  (dec_v),
    .com_o  (com_v),
    .rr_o   (rr_v),
    .rl_o   (rl_v),
    .swap_o (swap_v)
  );

  always_comb begin
    res  = '0;
    fl   = '0;
    unique case (op)
      ADD_F, ADD_L, SUB_F, SUB_L: begin
        res   = as_sum;
        fl.c  = as_c;
        fl.dc = as_dc;
      end
      AND_F, AND_L:     res = opnd & w_i;
      IOR_F, IOR_L:     res = opnd | w_i;
      XOR_F, XOR_L:     res = opnd ^ w_i;
      MOV_F:            res = f_i;
      MOV_WF:           res = w_i;
      MOV_L:            res = k_i;
      CLR_F, CLR_W:     res = '0;
      INC_F, INCSK_F:   res = inc_v;
      DEC_F, DECSK_F:   res = dec_v;
      COM_F:            res = com_v;
      RRC_F: begin
        res  = rr_v;
        fl.c = f_i[0];
      end
      RLC_F: begin
        res  = rl_v;
        fl.c = f_i[DATA_W-1];
      end
      SWAP_F:           res = swap_v;
      default:          res = '0;
    endcase
    fl.z = (res == '0);
    skip = ((op == INCSK_F) || (op == DECSK_F)) && (res == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      dest_f_o <= 1'b0;
      c_o      <= 1'b0;
      dc_o     <= 1'b0;
      z_o      <= 1'b0;
      c_we_o   <= 1'b0;
      dc_we_o  <= 1'b0;
      z_we_o   <= 1'b0;
      skip_o   <= 1'b0;
    end else begin
      result_o <= res;
      dest_f_o <= dest_f;
      c_o      <= fl.c;
      dc_o     <= fl.dc;
      z_o      <= fl.z;
      c_we_o   <= we.c;
      dc_we_o  <= we.dc;
      z_we_o   <= we.z;
      skip_o   <= skip;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] op_i,
  input logic [7:0] f_i,
  input logic       d_i,
  input logic       c_i,
  input logic [7:0] result_o,
  input logic       dest_f_o,
  input logic       c_o,
  input logic       z_o,
  input logic       c_we_o,
  input logic       dc_we_o,
  input logic       z_we_o,
  input logic       skip_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  AST_ADDSUB_ALL_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) <= 5'h03 |-> c_we_o && dc_we_o && z_we_o); // R1

  AST_LOGIC_Z_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && (($past(op_i) >= 5'h04 && $past(op_i) <= 5'h0A) || $past(op_i) == 5'h0F
      || $past(op_i) == 5'h10 || $past(op_i) == 5'h13)
    |-> z_we_o && !c_we_o && !dc_we_o); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ($past(op_i) == 5'h0D || $past(op_i) == 5'h0E)
    |-> result_o == 8'h00 && z_o && z_we_o && !c_we_o && !dc_we_o); // R4

  AST_NO_FLAG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ($past(op_i) == 5'h0B || $past(op_i) == 5'h0C || $past(op_i) == 5'h11
      || $past(op_i) == 5'h12 || $past(op_i) == 5'h16)
    |-> !c_we_o && !dc_we_o && !z_we_o); // R5

  AST_RRC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) == 5'h14
    |-> c_we_o && !z_we_o && !dc_we_o && c_o == $past(f_i[0]) && result_o[7] == $past(c_i)); // R6

  AST_RLC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) == 5'h15
    |-> c_we_o && !z_we_o && !dc_we_o && c_o == $past(f_i[7]) && result_o[0] == $past(c_i)); // R6

  AST_SWAP_NIBBLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) == 5'h16
    |-> result_o == {$past(f_i[3:0]), $past(f_i[7:4])}); // R7

  AST_LIT_DEST_W: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ($past(op_i) == 5'h01 || $past(op_i) == 5'h03 || $past(op_i) == 5'h05
      || $past(op_i) == 5'h07 || $past(op_i) == 5'h09 || $past(op_i) == 5'h0C
      || $past(op_i) == 5'h0E)
    |-> !dest_f_o); // R8

  AST_REG_DEST_D: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ($past(op_i) == 5'h00 || $past(op_i) == 5'h02 || $past(op_i) == 5'h16)
    |-> dest_f_o == $past(d_i)); // R8

  AST_SKIP_ONLY_SKIPOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> result_o == 8'h00 && !z_we_o); // R9

  AST_Z_MATCHES_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_we_o |-> z_o == (result_o == 8'h00)); // R10

  AST_UNDEF_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) >= 5'h17
    |-> result_o == 8'h00 && !c_we_o && !dc_we_o && !z_we_o && !dest_f_o && !skip_o); // R12

  always_comb
    if (!rst_ni)
      AST_RESET_QUIET: assert (result_o == 8'h00 && !c_we_o && !dc_we_o && !z_we_o
                               && !skip_o && !dest_f_o); // R11
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .f_i      (f_i),
  .d_i      (d_i),
  .c_i      (c_i),
  .result_o (result_o),
  .dest_f_o (dest_f_o),
  .c_o      (c_o),
  .z_o      (z_o),
  .c_we_o   (c_we_o),
  .dc_we_o  (dc_we_o),
  .z_we_o   (z_we_o),
  .skip_o   (skip_o)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] w = '0, f = '0, k = '0;
  logic       d = 1'b0, cin = 1'b0;
  logic [7:0] result;
  logic       dest_f, c, dc, z, c_we, dc_we, z_we, skip;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  acc_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .w_i(w), .f_i(f), .k_i(k),
    .d_i(d), .c_i(cin), .result_o(result), .dest_f_o(dest_f), .c_o(c),
    .dc_o(dc), .z_o(z), .c_we_o(c_we), .dc_we_o(dc_we), .z_we_o(z_we),
    .skip_o(skip)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, registered result visible at the following negedge
  task automatic run(input logic [4:0] o, input logic [7:0] wv, input logic [7:0] fv,
                     input logic [7:0] kv, input logic dv, input logic cv);
    @(negedge clk);
    op = o; w = wv; f = fv; k = kv; d = dv; cin = cv;
    @(negedge clk);
  endtask

  // we = {c_we, dc_we, z_we}
  task automatic chk_all(input string tag, input logic [7:0] r, input logic [2:0] we,
                         input logic [2:0] fl, input logic dst);
    chk({tag, " result"}, result, r);
    chk({tag, " we"}, {5'b0, c_we, dc_we, z_we}, {5'b0, we});
    if (we[2]) chk({tag, " C"}, {7'b0, c}, {7'b0, fl[2]});
    if (we[1]) chk({tag, " DC"}, {7'b0, dc}, {7'b0, fl[1]});
    if (we[0]) chk({tag, " Z"}, {7'b0, z}, {7'b0, fl[0]});
    chk({tag, " dest"}, {7'b0, dest_f}, {7'b0, dst});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 reset result", result, 8'h00);
    chk("R11 reset enables", {5'b0, c_we, dc_we, z_we}, 8'h00);
    chk("R11 reset skip/dest", {6'b0, skip, dest_f}, 8'h00);
  endtask

  task automatic t_add;
    run(5'h00, 8'h3A, 8'hC6, 8'h00, 1'b1, 1'b0);
    chk_all("R1 addf wrap", 8'h00, 3'b111, 3'b111, 1'b1);
    run(5'h01, 8'h12, 8'h00, 8'h34, 1'b1, 1'b0);
    chk_all("R1 addl plain", 8'h46, 3'b111, 3'b000, 1'b0);
    run(5'h01, 8'h0F, 8'h00, 8'h01, 1'b0, 1'b0);
    chk_all("R1 addl nibble carry", 8'h10, 3'b111, 3'b010, 1'b0);
  endtask

  task automatic t_sub;
    run(5'h02, 8'h01, 8'h10, 8'h00, 1'b0, 1'b0);
    chk_all("R2 subf nibble borrow", 8'h0F, 3'b111, 3'b100, 1'b0);
    run(5'h03, 8'h07, 8'h00, 8'h05, 1'b1, 1'b0);
    chk_all("R2 subl borrow", 8'hFE, 3'b111, 3'b000, 1'b0);
    run(5'h02, 8'h22, 8'h22, 8'h00, 1'b1, 1'b0);
    chk_all("R2 subf equal", 8'h00, 3'b111, 3'b111, 1'b1);
  endtask

  task automatic t_logic;
    run(5'h04, 8'h0F, 8'hF0, 8'h00, 1'b1, 1'b1);
    chk_all("R3 andf zero", 8'h00, 3'b001, 3'b001, 1'b1);
    run(5'h06, 8'h02, 8'h81, 8'h00, 1'b0, 1'b0);
    chk_all("R3 iorf", 8'h83, 3'b001, 3'b000, 1'b0);
    run(5'h09, 8'h0F, 8'h00, 8'hFF, 1'b1, 1'b0);
    chk_all("R3 xorl dest W R8", 8'hF0, 3'b001, 3'b000, 1'b0);
    run(5'h13, 8'h00, 8'h55, 8'h00, 1'b1, 1'b1);
    chk_all("R3 comf", 8'hAA, 3'b001, 3'b000, 1'b1);
    run(5'h0A, 8'h11, 8'h00, 8'h00, 1'b0, 1'b0);
    chk_all("R3 R10 movf zero test", 8'h00, 3'b001, 3'b001, 1'b0);
  endtask

  task automatic t_incdec;
    run(5'h0F, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0);
    chk_all("R3 incf wrap", 8'h00, 3'b001, 3'b001, 1'b1);
    run(5'h10, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0);
    chk_all("R3 decf zero", 8'h00, 3'b001, 3'b001, 1'b0);
    run(5'h11, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0);
    chk_all("R5 incsk", 8'h00, 3'b000, 3'b000, 1'b1);
    chk("R9 incsk skip", {7'b0, skip}, 8'h01);
    run(5'h12, 8'h00, 8'h05, 8'h00, 1'b0, 1'b0);
    chk_all("R5 decsk", 8'h04, 3'b000, 3'b000, 1'b0);
    chk("R9 decsk no skip", {7'b0, skip}, 8'h00);
    run(5'h0F, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0);
    chk("R9 incf never skips", {7'b0, skip}, 8'h00);
  endtask

  task automatic t_clear_move;
    run(5'h0D, 8'h44, 8'h99, 8'h00, 1'b0, 1'b1);
    chk_all("R4 R8 clrf", 8'h00, 3'b001, 3'b001, 1'b1);
    run(5'h0E, 8'h44, 8'h99, 8'h00, 1'b1, 1'b1);
    chk_all("R4 R8 clrw", 8'h00, 3'b001, 3'b001, 1'b0);
    run(5'h0B, 8'h9C, 8'h00, 8'h00, 1'b0, 1'b0);
    chk_all("R5 R8 movwf", 8'h9C, 3'b000, 3'b000, 1'b1);
    run(5'h0C, 8'h00, 8'h00, 8'h7E, 1'b1, 1'b0);
    chk_all("R5 movl", 8'h7E, 3'b000, 3'b000, 1'b0);
  endtask

  task automatic t_rotate_swap;
    run(5'h14, 8'h00, 8'h01, 8'h00, 1'b1, 1'b0);
    chk_all("R6 rrc out", 8'h00, 3'b100, 3'b100, 1'b1);
    run(5'h14, 8'h00, 8'h02, 8'h00, 1'b0, 1'b1);
    chk_all("R6 rrc in", 8'h81, 3'b100, 3'b000, 1'b0);
    run(5'h15, 8'h00, 8'h80, 8'h00, 1'b0, 1'b1);
    chk_all("R6 rlc", 8'h01, 3'b100, 3'b100, 1'b0);
    run(5'h16, 8'h00, 8'hA5, 8'h00, 1'b1, 1'b0);
    chk_all("R7 R5 swap", 8'h5A, 3'b000, 3'b000, 1'b1);
  endtask

  task automatic t_undef;
    for (int o = 5'h17; o <= 5'h1F; o += 4) begin
      run(5'(o), 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1);
      chk_all("R12 undefined op", 8'h00, 3'b000, 3'b000, 1'b0);
      chk("R12 undefined skip", {7'b0, skip}, 8'h00);
    end
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_logic();
    t_incdec();
    t_clear_move();
    t_rotate_swap();
    t_undef();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule